// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block buffers 9-bit words between two unrelated clock domains. A producer pushes words on the write clock and a consumer pulls them on the read clock. A push happens only when both write enables are high. A pull happens only when both read enables are high. Storage depth is a parameter and must be one of 64, 256, 512, 1024, 2048, 4096 or 8192 words.

Four active-low status outputs report occupancy. Each is produced in the domain that needs it. The write side drives `full_n` and `almost_full_n` from wclk. The read side drives `empty_n` and `almost_empty_n` from rclk.

- The low threshold `n` and the high margin `m` are held in offset registers in the write domain. Both reset to 7 and are loaded through a strobe.
- Pointers cross between domains as Gray codes through two-flop synchronizers.
- A flag that depends on the other domain therefore lags by a few edges of its own clock. It always errs on the safe side.

Each side is a three-state machine whose state is recomputed on every edge of its clock from the occupancy projected after that edge.

| Side | State | Meaning | `empty_n` / `full_n` | `almost_empty_n` / `almost_full_n` |
|---|---|---|---|---|
| Read | `RS_EMPTY` | projected count is 0 | `empty_n`=0 | `almost_empty_n`=0 |
| Read | `RS_LOW` | count is 1 to n | `empty_n`=1 | `almost_empty_n`=0 |
| Read | `RS_READY` | count is above n | `empty_n`=1 | `almost_empty_n`=1 |
| Write | `WS_ROOM` | count is below DEPTH-m | `full_n`=1 | `almost_full_n`=1 |
| Write | `WS_HIGH` | count is DEPTH-m up to DEPTH-1 | `full_n`=1 | `almost_full_n`=0 |
| Write | `WS_FULL` | count is DEPTH | `full_n`=0 | `almost_full_n`=0 |

Any state may move to any other state of the same side on a single edge: a jump follows the projected count, not a fixed sequence. Reset places the read side in `RS_EMPTY` and the write side in `WS_ROOM`.

Top module: `dcfifo_progflags`

## Requirements
- R1: Words come out of `rd_data` in the order they were accepted, with all 9 bits intact. `rd_data` updates on the rclk edge that performs the read.
- R2: A write needs `wr_en_a` and `wr_en_b` both high on a wclk edge. A read needs `rd_en_a` and `rd_en_b` both high on an rclk edge. Any other enable combination changes nothing.
- R3: A write attempted while `full_n` is 0 is dropped. The write pointer holds and the stored words are unchanged.
- R4: A read attempted while `empty_n` is 0 is ignored. The read pointer and `rd_data` hold.
- R5: While `rst_n` is low, and right after it is released, the flags read `empty_n`=0, `almost_empty_n`=0, `full_n`=1 and `almost_full_n`=1. `rd_data` is 0 and both offsets are 7.
- R6: Once traffic has been quiet for a few edges, `almost_empty_n` is 0 exactly when the stored count is at most n. It changes only on rclk edges.
- R7: Once traffic has been quiet for a few edges, `almost_full_n` is 0 exactly when the stored count is at least DEPTH-m. It changes only on wclk edges.
- R8: Once traffic has been quiet for a few edges, `full_n` is 0 exactly when the count equals DEPTH, and `empty_n` is 0 exactly when the count is 0. Full implies almost-full, and empty implies almost-empty.
- R9: During traffic, the flags stay conservative. `empty_n` is high only when at least one word is stored, and `full_n` is high only when at least one slot is free.
- R10: A wclk edge with `ofs_load` high writes `ofs_value` into one offset register. `ofs_sel`=0 selects n and `ofs_sel`=1 selects m. Later flag decisions use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en_a | input | 1 | First write enable, active high |
| wr_en_b | input | 1 | Second write enable, active high |
| wr_data | input | 9 | Word to store |
| ofs_load | input | 1 | Load strobe for an offset register (wclk) |
| ofs_sel | input | 1 | 0 selects the low threshold n, 1 selects the high margin m |
| ofs_value | input | $clog2(DEPTH) | Value to load |
| full_n | output | 1 | Low when no slot is free (wclk) |
| almost_full_n | output | 1 | Low when count is at least DEPTH-m (wclk) |
| rclk | input | 1 | Read-domain clock |
| rd_en_a | input | 1 | First read enable, active high |
| rd_en_b | input | 1 | Second read enable, active high |
| rd_data | output | 9 | Word most recently read |
| empty_n | output | 1 | Low when nothing is stored (rclk) |
| almost_empty_n | output | 1 | Low when count is at most n (rclk) |

## Verification
The bench targets the flag thresholds at their exact boundaries: counts of n and n+1, DEPTH-m-1 and DEPTH-m, and 0 and DEPTH. It checks them under both the reset offsets and newly loaded offsets. An off-by-one comparison would move a flag one word early or late, and a load routed to the wrong register would leave one flag at its old threshold.

Writes are pushed at a full FIFO and reads at an empty one. A design that let a pointer wrap there would return a stray word or replay an old word when the FIFO is drained. Single-enable pulses on each port are also driven, and an enable decoded as OR would insert or consume a phantom word.

While the clocks run unrelated, the bench watches for a flag that claims data or space before it exists. That error is what a synchronizer using unsynchronized or binary pointers would produce.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    localparam int WORD_W    = 9;
    localparam int OFS_RESET = 7;

    typedef enum logic [1:0] {
        RS_EMPTY,
        RS_LOW,
        RS_READY
    } rd_state_t;

    typedef enum logic [1:0] {
        WS_ROOM,
        WS_HIGH,
        WS_FULL
    } wr_state_t;

endpackage

// File: rtl/fifo_sync2.sv
module fifo_sync2 #(
    parameter int W       = 4,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= W'(RST_VAL);
            stage2 <= W'(RST_VAL);
        end else begin
            stage1 <= d_in;
            stage2 <= stage1;
        end
    end

    assign d_out = stage2;

endmodule

// File: rtl/fifo_ram.sv
module fifo_ram #(
    parameter int DEPTH = 64,
    parameter int W     = 9,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= cells[raddr];
        end
    end

endmodule

// File: rtl/fifo_wr_ctrl.sv
module fifo_wr_ctrl
    import fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wr_en_a,
    input  logic          wr_en_b,
    input  logic          ofs_load,
    input  logic          ofs_sel,
    input  logic [AW-1:0] ofs_value,
    input  logic [PW-1:0] rgray_s,
    output logic          wr_ok,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] ofs_low,
    output logic          full_n,
    output logic          almost_full_n
);

    wr_state_t     state, state_nxt;
    logic [PW-1:0] wptr_nxt;
    logic [PW-1:0] rptr_b;
    logic [PW-1:0] used_nxt;
    logic [AW-1:0] ofs_high;

    // Gray to binary for the synchronized read pointer
    always_comb begin
        rptr_b[PW-1] = rgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            rptr_b[i] = rptr_b[i+1] ^ rgray_s[i];
        end
    end

    assign wr_ok    = wr_en_a & wr_en_b & (state != WS_FULL);
    assign wptr_nxt = wptr + PW'(wr_ok);
    assign used_nxt = wptr_nxt - rptr_b;
    assign waddr    = wptr[AW-1:0];

    // Next state from the occupancy projected after this edge
    always_comb begin
        if (used_nxt == PW'(DEPTH)) begin
            state_nxt = WS_FULL;
        end else if (used_nxt >= (PW'(DEPTH) - PW'(ofs_high))) begin
            state_nxt = WS_HIGH;
        end else begin
            state_nxt = WS_ROOM;
        end
    end

    // State register
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WS_ROOM;
        end else begin
            state <= state_nxt;
        end
    end

    // Pointer and offset registers
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wptr     <= '0;
            wgray    <= '0;
            ofs_low  <= AW'(OFS_RESET);
            ofs_high <= AW'(OFS_RESET);
        end else begin
            wptr  <= wptr_nxt;
            wgray <= wptr_nxt ^ (wptr_nxt >> 1);
            if (ofs_load) begin
                if (ofs_sel) begin
                    ofs_high <= ofs_value;
                end else begin
                    ofs_low  <= ofs_value;
                end
            end
        end
    end

    // Flag outputs
    always_comb begin
        unique case (state)
            WS_ROOM: begin full_n = 1'b1; almost_full_n = 1'b1; end
            WS_HIGH: begin full_n = 1'b1; almost_full_n = 1'b0; end
            WS_FULL: begin full_n = 1'b0; almost_full_n = 1'b0; end
            default: begin full_n = 1'b0; almost_full_n = 1'b0; end
        endcase
    end

endmodule

// File: rtl/fifo_rd_ctrl.sv
module fifo_rd_ctrl
    import fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          rd_en_a,
    input  logic          rd_en_b,
    input  logic [PW-1:0] wgray_s,
    input  logic [AW-1:0] ofs_low_s,
    output logic          rd_ok,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rptr,
    output logic [PW-1:0] rgray,
    output logic          empty_n,
    output logic          almost_empty_n
);

    rd_state_t     state, state_nxt;
    logic [PW-1:0] rptr_nxt;
    logic [PW-1:0] wptr_b;
    logic [PW-1:0] avail_nxt;

    // Gray to binary for the synchronized write pointer
    always_comb begin
        wptr_b[PW-1] = wgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wptr_b[i] = wptr_b[i+1] ^ wgray_s[i];
        end
    end

    assign rd_ok     = rd_en_a & rd_en_b & (state != RS_EMPTY);
    assign rptr_nxt  = rptr + PW'(rd_ok);
    assign avail_nxt = wptr_b - rptr_nxt;
    assign raddr     = rptr[AW-1:0];

    // Next state from the occupancy projected after this edge
    always_comb begin
        if (avail_nxt == '0) begin
            state_nxt = RS_EMPTY;
        end else if (avail_nxt <= PW'(ofs_low_s)) begin
            state_nxt = RS_LOW;
        end else begin
            state_nxt = RS_READY;
        end
    end

    // State register
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RS_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    // Pointer registers
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rptr  <= '0;
            rgray <= '0;
        end else begin
            rptr  <= rptr_nxt;
            rgray <= rptr_nxt ^ (rptr_nxt >> 1);
        end
    end

    // Flag outputs
    always_comb begin
        unique case (state)
            RS_EMPTY: begin empty_n = 1'b0; almost_empty_n = 1'b0; end
            RS_LOW:   begin empty_n = 1'b1; almost_empty_n = 1'b0; end
            RS_READY: begin empty_n = 1'b1; almost_empty_n = 1'b1; end
            default:  begin empty_n = 1'b0; almost_empty_n = 1'b0; end
        endcase
    end

endmodule

// File: rtl/dcfifo_progflags.sv
module dcfifo_progflags
    import fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic              wr_en_a,
    input  logic              wr_en_b,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              ofs_load,
    input  logic              ofs_sel,
    input  logic [AW-1:0]     ofs_value,
    output logic              full_n,
    output logic              almost_full_n,
    input  logic              rclk,
    input  logic              rd_en_a,
    input  logic              rd_en_b,
    output logic [WORD_W-1:0] rd_data,
    output logic              empty_n,
    output logic              almost_empty_n
);

    logic          wr_ok, rd_ok;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [PW-1:0] wr_gray, rd_gray;
    logic [PW-1:0] wr_gray_s, rd_gray_s;
    logic [AW-1:0] ofs_low, ofs_low_s;

    fifo_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .wclk          (wclk),
        .rst_n         (rst_n),
        .wr_en_a       (wr_en_a),
        .wr_en_b       (wr_en_b),
        .ofs_load      (ofs_load),
        .ofs_sel       (ofs_sel),
        .ofs_value     (ofs_value),
        .rgray_s       (rd_gray_s),
        .wr_ok         (wr_ok),
        .waddr         (waddr),
        .wptr          (wr_ptr),
        .wgray         (wr_gray),
        .ofs_low       (ofs_low),
        .full_n        (full_n),
        .almost_full_n (almost_full_n)
    );

    fifo_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .rclk           (rclk),
        .rst_n          (rst_n),
        .rd_en_a        (rd_en_a),
        .rd_en_b        (rd_en_b),
        .wgray_s        (wr_gray_s),
        .ofs_low_s      (ofs_low_s),
        .rd_ok          (rd_ok),
        .raddr          (raddr),
        .rptr           (rd_ptr),
        .rgray          (rd_gray),
        .empty_n        (empty_n),
        .almost_empty_n (almost_empty_n)
    );

    fifo_sync2 #(.W(PW), .RST_VAL(0)) u_sync_r2w (
        .clk   (wclk),
        .rst_n (rst_n),
        .d_in  (rd_gray),
        .d_out (rd_gray_s)
    );

    fifo_sync2 #(.W(PW), .RST_VAL(0)) u_sync_w2r (
        .clk   (rclk),
        .rst_n (rst_n),
        .d_in  (wr_gray),
        .d_out (wr_gray_s)
    );

    fifo_sync2 #(.W(AW), .RST_VAL(OFS_RESET)) u_sync_ofs (
        .clk   (rclk),
        .rst_n (rst_n),
        .d_in  (ofs_low),
        .d_out (ofs_low_s)
    );

    fifo_ram #(.DEPTH(DEPTH), .W(WORD_W)) u_ram (
        .wclk  (wclk),
        .we    (wr_ok),
        .waddr (waddr),
        .wdata (wr_data),
        .rclk  (rclk),
        .rst_n (rst_n),
        .re    (rd_ok),
        .raddr (raddr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/fifo_chk.sv
module fifo_chk #(
    parameter int PW = 7
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          full_n,
    input logic          almost_full_n,
    input logic          empty_n,
    input logic          almost_empty_n,
    input logic [PW-1:0] wr_ptr,
    input logic [PW-1:0] rd_ptr,
    input logic [PW-1:0] wr_gray,
    input logic [PW-1:0] rd_gray
);

    // R3
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |=> $stable(wr_ptr));

    // R4
    no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |=> $stable(rd_ptr));

    // R8
    full_implies_high_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !almost_full_n);

    // R8
    empty_implies_low_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !almost_empty_n);

    // R1
    wr_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_ptr == $past(wr_ptr)) || (wr_ptr == $past(wr_ptr) + PW'(1)));

    // R1
    rd_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_ptr == $past(rd_ptr)) || (rd_ptr == $past(rd_ptr) + PW'(1)));

    // R9
    wr_gray_onebit_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    // R9
    rd_gray_onebit_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);

endmodule

bind dcfifo_progflags fifo_chk #(.PW(PW)) u_chk (
    .wclk           (wclk),
    .rclk           (rclk),
    .rst_n          (rst_n),
    .full_n         (full_n),
    .almost_full_n  (almost_full_n),
    .empty_n        (empty_n),
    .almost_empty_n (almost_empty_n),
    .wr_ptr         (wr_ptr),
    .rd_ptr         (rd_ptr),
    .wr_gray        (wr_gray),
    .rd_gray        (rd_gray)
);

// File: tb/dcfifo_progflags_bench.sv
module dcfifo_progflags_bench;

    localparam int DEPTH = 64;
    localparam int AW    = $clog2(DEPTH);
    localparam int NVEC  = 8;

    // {writes, reads, expected {empty_n, almost_empty_n, full_n, almost_full_n}}
    localparam logic [19:0] VEC [NVEC] = '{
        {8'd5,  8'd0,  4'b1011},
        {8'd3,  8'd0,  4'b1111},
        {8'd0,  8'd1,  4'b1011},
        {8'd50, 8'd0,  4'b1110},
        {8'd0,  8'd1,  4'b1111},
        {8'd8,  8'd0,  4'b1100},
        {8'd0,  8'd64, 4'b0011},
        {8'd1,  8'd0,  4'b1011}
    };

    logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic          wr_en_a = 1'b0, wr_en_b = 1'b0;
    logic [8:0]    wr_data = '0;
    logic          ofs_load = 1'b0, ofs_sel = 1'b0;
    logic [AW-1:0] ofs_value = '0;
    logic          rd_en_a = 1'b0, rd_en_b = 1'b0;
    logic          full_n, almost_full_n, empty_n, almost_empty_n;
    logic [8:0]    rd_data;

    int         checks = 0, errors = 0;
    int         wr_done = 0, rd_done = 0;
    logic [8:0] next_word = 9'h001;
    logic [8:0] model_q [$];
    logic       mon_on = 1'b0;
    logic       done = 1'b0;

    always #5   wclk = ~wclk;
    always #6.5 rclk = ~rclk;

    dcfifo_progflags #(.DEPTH(DEPTH)) u_dcfifo_progflags (
        .wclk           (wclk),
        .rst_n          (rst_n),
        .wr_en_a        (wr_en_a),
        .wr_en_b        (wr_en_b),
        .wr_data        (wr_data),
        .ofs_load       (ofs_load),
        .ofs_sel        (ofs_sel),
        .ofs_value      (ofs_value),
        .full_n         (full_n),
        .almost_full_n  (almost_full_n),
        .rclk           (rclk),
        .rd_en_a        (rd_en_a),
        .rd_en_b        (rd_en_b),
        .rd_data        (rd_data),
        .empty_n        (empty_n),
        .almost_empty_n (almost_empty_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write();
        @(negedge wclk);
        while (!full_n) @(negedge wclk);
        wr_data = next_word;
        wr_en_a = 1'b1;
        wr_en_b = 1'b1;
        @(negedge wclk);
        wr_en_a = 1'b0;
        wr_en_b = 1'b0;
        model_q.push_back(next_word);
        next_word = next_word + 9'h0A7;
        wr_done++;
    endtask

    task automatic do_read();
        logic [8:0] exp;
        @(negedge rclk);
        while (!empty_n) @(negedge rclk);
        rd_en_a = 1'b1;
        rd_en_b = 1'b1;
        @(negedge rclk);
        rd_en_a = 1'b0;
        rd_en_b = 1'b0;
        rd_done++;
        exp = model_q.pop_front();
        check("R1 read order", 32'(rd_data), 32'(exp));
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
        repeat (8) @(negedge wclk);
    endtask

    task automatic check_flags(input string tag, input logic [3:0] exp);
        check(tag, {28'd0, empty_n, almost_empty_n, full_n, almost_full_n}, {28'd0, exp});
    endtask

    // R9: conservative flags while traffic runs
    always @(negedge rclk) begin
        if (mon_on) begin
            checks++;
            if (empty_n && (wr_done - rd_done) <= 0) begin
                errors++;
                $display("FAIL R9 empty_n actual=1 expected=0 (count %0d)", wr_done - rd_done);
            end
        end
    end

    always @(negedge wclk) begin
        if (mon_on) begin
            checks++;
            if (full_n && (wr_done - rd_done) >= DEPTH) begin
                errors++;
                $display("FAIL R9 full_n actual=1 expected=0 (count %0d)", wr_done - rd_done);
            end
        end
    end

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] last;

        // R5: reset state
        repeat (3) @(negedge wclk);
        check_flags("R5 flags in reset", 4'b0011);
        check("R5 rd_data in reset", 32'(rd_data), 32'h0);
        rst_n = 1'b1;
        settle();
        check_flags("R5 flags after reset", 4'b0011);
        mon_on = 1'b1;

        // R6 R7 R8 with default offsets of 7, table driven
        for (int v = 0; v < NVEC; v++) begin
            for (int k = 0; k < int'(VEC[v][19:12]); k++) do_write();
            for (int k = 0; k < int'(VEC[v][11:4]); k++) do_read();
            settle();
            check_flags($sformatf("R6 R7 R8 vector %0d", v), VEC[v][3:0]);
        end

        // R2: single-enable writes and reads change nothing (count is 1)
        @(negedge wclk);
        wr_data = 9'h1FF;
        wr_en_a = 1'b1;
        repeat (4) @(negedge wclk);
        wr_en_a = 1'b0;
        wr_en_b = 1'b1;
        repeat (4) @(negedge wclk);
        wr_en_b = 1'b0;
        @(negedge rclk);
        rd_en_a = 1'b1;
        repeat (4) @(negedge rclk);
        rd_en_a = 1'b0;
        rd_en_b = 1'b1;
        repeat (4) @(negedge rclk);
        rd_en_b = 1'b0;
        settle();
        check("R2 word still stored", 32'(empty_n), 32'h1);
        do_read();
        settle();
        check("R2 no phantom word", 32'(empty_n), 32'h0);

        // R4: read while empty is ignored
        last = rd_data;
        @(negedge rclk);
        rd_en_a = 1'b1;
        rd_en_b = 1'b1;
        repeat (4) @(negedge rclk);
        rd_en_a = 1'b0;
        rd_en_b = 1'b0;
        settle();
        check("R4 rd_data holds", 32'(rd_data), 32'(last));
        check("R4 still empty", 32'(empty_n), 32'h0);
        do_write();
        do_read();
        settle();

        // R3: write while full is dropped
        for (int k = 0; k < DEPTH; k++) do_write();
        settle();
        check("R3 full reached", 32'(full_n), 32'h0);
        @(negedge wclk);
        wr_data = 9'h155;
        wr_en_a = 1'b1;
        wr_en_b = 1'b1;
        repeat (4) @(negedge wclk);
        wr_en_a = 1'b0;
        wr_en_b = 1'b0;
        settle();
        check("R3 still full", 32'(full_n), 32'h0);
        for (int k = 0; k < DEPTH; k++) do_read();
        settle();
        check("R3 no extra word", 32'(empty_n), 32'h0);

        // R10: load n=2 (ofs_sel 0) and m=1 (ofs_sel 1)
        @(negedge wclk);
        ofs_load = 1'b1;
        ofs_sel = 1'b0;
        ofs_value = AW'(2);
        @(negedge wclk);
        ofs_sel = 1'b1;
        ofs_value = AW'(1);
        @(negedge wclk);
        ofs_load = 1'b0;
        settle();
        for (int k = 0; k < 2; k++) do_write();
        settle();
        check("R10 R6 count 2 with n=2", 32'(almost_empty_n), 32'h0);
        do_write();
        settle();
        check("R10 R6 count 3 with n=2", 32'(almost_empty_n), 32'h1);
        for (int k = 0; k < DEPTH - 4; k++) do_write();
        settle();
        check("R10 R7 count 63 with m=1", 32'(almost_full_n), 32'h0);
        check("R10 R8 count 63 not full", 32'(full_n), 32'h1);
        do_read();
        settle();
        check("R10 R7 count 62 with m=1", 32'(almost_full_n), 32'h1);
        while (model_q.size() > 0) do_read();
        settle();
        check_flags("R8 drained", 4'b0011);

        mon_on = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule